// File: doc/BRIEF.md
# Coded-Ratio Audio Clock Divider

This block derives two audio clocks from a single module clock: a master clock for an external converter and a bit clock for the serial data lanes. Each clock has its own 4-bit divider code. The code does not act as a binary divisor. It indexes a fixed table of mostly non-power-of-two ratios, which lets one module clock serve several sample-rate families. The bit clock ratio is chosen as the bit-clock source rate divided by (2 × slot width × sample rate). For example, a 24.576 MHz module clock with two 32-bit slots at 48 kHz needs a bit-clock divide of 8.

Every divided output has a 50% duty cycle. Ratio 1 passes the module clock straight through. Code 0 has no ratio: the output affected by it is held low and an error flag is raised. A code change on a running divider is deferred to the output's next rising edge, so the output never emits a shortened pulse. Both dividers run off the same synchronous counter domain. The master clock reaches its pin only while its output enable is high.

Top module: `audio_clkdiv`

## Requirements
- R1: Codes 1 to 15 select ratios 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 176 and 192, in that order. A divided output repeats every ratio module-clock cycles.
- R2: For any ratio of 2 or more, the output is high for ratio/2 cycles and then low for ratio/2 cycles.
- R3: With code 1 applied, the output equals the module clock, both while the module clock is high and while it is low.
- R4: With code 0 applied, that output stays low. `code_bad_o` is high whenever either channel has code 0 applied, and the other channel keeps running unaffected.
- R5: While `mclk_oe_i` is low, `mclk_o` is low. `bclk_o` is unaffected, and the master clock resumes its full ratio once the enable returns.
- R6: On a running divided output, a new code is applied only at the output's next rising edge. The high and low phases in progress complete at the old ratio, and the following high phase uses the new one.
- R7: When the applied code is 0 or 1, a new input code is applied at the next module-clock edge. If the new code is a divided ratio, the output goes high at that edge and `code_bad_o` clears in the same cycle.
- R8: While `rst_ni` is low, both clocks are low and `code_bad_o` is high. After release, the input codes are applied on the third module-clock edge.
- R9: Two channels given the same code are applied on the same edge and produce identical waveforms.
- R10: Bit-clock code 5 divides by 8, which gives 64 bit clocks per sample at 48 kHz from 24.576 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mclk_code_i | input | 4 | Master clock divider code |
| bclk_code_i | input | 4 | Bit clock divider code |
| mclk_oe_i | input | 1 | Master clock output enable |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| code_bad_o | output | 1 | High while either applied code is 0 |

## Verification
The bench measures high and low run lengths for all fourteen divided codes. A wrong table entry or an off-by-one terminal count shows up as a skewed duty cycle or a wrong period. It changes a code during a high phase and expects the old phase pair to finish before a long new high phase. A design that reloads immediately would emit a clipped pulse or restart mid-phase. It also checks pass-through at both clock levels, the low hold and error flag for code 0, the immediate pickup out of a held state, the enable gating, and that identical codes started together stay in lock-step. A divider that reset its counters unevenly would drift apart under that last check.

// File: rtl/acd_pkg.sv
package acd_pkg;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 8;
  localparam int CNT_W   = RATIO_W - 1;
  localparam int NCH     = 2;

  // Nonlinear ratio lookup; code 0 is reserved and returns 0.
  function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
    logic [RATIO_W-1:0] r;
    case (c)
      4'd1:    r = 8'd1;
      4'd2:    r = 8'd2;
      4'd3:    r = 8'd4;
      4'd4:    r = 8'd6;
      4'd5:    r = 8'd8;
      4'd6:    r = 8'd12;
      4'd7:    r = 8'd16;
      4'd8:    r = 8'd24;
      4'd9:    r = 8'd32;
      4'd10:   r = 8'd48;
      4'd11:   r = 8'd64;
      4'd12:   r = 8'd96;
      4'd13:   r = 8'd128;
      4'd14:   r = 8'd176;
      4'd15:   r = 8'd192;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/acd_rst_sync.sv
module acd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_r <= '0;
    else         sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_r[STAGES-1];
endmodule

// File: rtl/acd_ratio_dec.sv
module acd_ratio_dec
  import acd_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  half_o,
  output logic              valid_o,
  output logic              pass_o
);
  logic [RATIO_W-1:0] ratio;

  always_comb begin
    ratio   = code_ratio(code_i);
    half_o  = ratio[RATIO_W-1:1];
    valid_o = (ratio != '0);
    pass_o  = (ratio == RATIO_W'(1));
  end
endmodule

// File: rtl/acd_chan.sv
module acd_chan
  import acd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_o,
  output logic              bad_o
);
  logic [CODE_W-1:0] act_r, act_n;
  logic [CNT_W-1:0]  cnt_r, cnt_n;
  logic              q_r, q_n;

  logic [CNT_W-1:0]  a_half;
  logic              a_valid, a_pass;
  logic [RATIO_W-1:0] n_ratio;
  logic              n_divided;
  logic              hold, at_limit, rise, fall, load;

  acd_ratio_dec u_dec (
    .code_i (act_r),
    .half_o (a_half),
    .valid_o(a_valid),
    .pass_o (a_pass)
  );

  always_comb begin
    n_ratio   = code_ratio(code_i);
    n_divided = (n_ratio > RATIO_W'(1));
    hold      = !a_valid || a_pass;
    at_limit  = (cnt_r == (a_half - CNT_W'(1)));
    rise      = !hold && at_limit && !q_r;
    fall      = !hold && at_limit && q_r;
    load      = hold || rise;
  end

  // Next state: codes are only adopted at a rising point or while held.
  always_comb begin
    act_n = act_r;
    cnt_n = cnt_r + CNT_W'(1);
    q_n   = q_r;
    if (load) begin
      act_n = code_i;
      cnt_n = '0;
      q_n   = n_divided;
    end else if (fall) begin
      cnt_n = '0;
      q_n   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_r <= '0;
      cnt_r <= '0;
      q_r   <= 1'b0;
    end else begin
      act_r <= act_n;
      cnt_r <= cnt_n;
      q_r   <= q_n;
    end
  end

  assign div_o = a_pass ? clk_i : q_r;
  assign bad_o = !a_valid;

  // R6
  hold_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold && !rise) |=> $stable(act_r));

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold |-> (cnt_r < a_half));

  // R2
  rise_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_r) |-> (cnt_r == '0));

  // R4
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_valid |-> !q_r);
endmodule

// File: rtl/audio_clkdiv.sv
module audio_clkdiv
  import acd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] mclk_code_i,
  input  logic [CODE_W-1:0] bclk_code_i,
  input  logic              mclk_oe_i,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              code_bad_o
);
  localparam int MCH = 0;
  localparam int BCH = 1;

  logic                         rst_sync_n;
  logic [NCH-1:0][CODE_W-1:0]   codes;
  logic [NCH-1:0]               ch_div, ch_bad;

  assign codes[MCH] = mclk_code_i;
  assign codes[BCH] = bclk_code_i;

  acd_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    acd_chan u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .code_i(codes[g]),
      .div_o (ch_div[g]),
      .bad_o (ch_bad[g])
    );
  end

  assign mclk_o     = ch_div[MCH] & mclk_oe_i;
  assign bclk_o     = ch_div[BCH];
  assign code_bad_o = |ch_bad;

  // R8
  rst_flag_chk: assert property (@(posedge clk_i)
    !rst_sync_n |-> (code_bad_o && !bclk_o));
endmodule

// File: tb/sim_audio_clkdiv.sv
module sim_audio_clkdiv;
  logic       clk, rst_n, oe;
  logic [3:0] mcode, bcode;
  logic       mclk, bclk, bad;
  int         n_tests, n_fail;

  typedef struct packed {
    logic [3:0] m;
    logic [3:0] b;
    logic [7:0] mr;
    logic [7:0] br;
  } vec_t;

  // R1 stimulus: every divided code, with expected ratios.
  localparam vec_t VEC [7] = '{
    '{4'd2, 4'd15, 8'd2,  8'd192},
    '{4'd3, 4'd14, 8'd4,  8'd176},
    '{4'd4, 4'd13, 8'd6,  8'd128},
    '{4'd5, 4'd12, 8'd8,  8'd96},
    '{4'd6, 4'd11, 8'd12, 8'd64},
    '{4'd7, 4'd10, 8'd16, 8'd48},
    '{4'd8, 4'd9,  8'd24, 8'd32}
  };

  audio_clkdiv u0 (
    .clk_i(clk), .rst_ni(rst_n), .mclk_code_i(mcode), .bclk_code_i(bcode),
    .mclk_oe_i(oe), .mclk_o(mclk), .bclk_o(bclk), .code_bad_o(bad)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    return (sel == 0) ? mclk : bclk;
  endfunction

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic measure(input int sel, output int hi, output int lo);
    int guard;
    logic v;
    hi = 0; lo = 0; guard = 0;
    do begin tick(); v = pick(sel); guard++; end while (v && guard < 1000);
    do begin tick(); v = pick(sel); guard++; end while (!v && guard < 2000);
    while (v && guard < 3000) begin hi++; tick(); v = pick(sel); guard++; end
    while (!v && guard < 4000) begin lo++; tick(); v = pick(sel); guard++; end
  endtask

  initial begin
    int hi, lo, errs;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; oe = 1'b1; mcode = 4'd6; bcode = 4'd6;
    repeat (3) tick();
    // R8 reset state
    check("R8 mclk in reset", mclk, 0);
    check("R8 bclk in reset", bclk, 0);
    check("R8 flag in reset", bad, 1);
    rst_n = 1'b1;
    // R9 identical codes loaded together stay identical
    errs = 0;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (mclk !== bclk) errs++;
    end
    check("R9 mclk/bclk lock-step mismatches", errs, 0);
    check("R8 flag clears after release", bad, 0);

    // R1/R2 table walk
    foreach (VEC[k]) begin
      mcode = VEC[k].m; bcode = VEC[k].b;
      measure(0, hi, lo);
      check("R1 mclk high run", hi, int'(VEC[k].mr) / 2);
      check("R2 mclk low run", lo, int'(VEC[k].mr) / 2);
      measure(1, hi, lo);
      check("R1 bclk high run", hi, int'(VEC[k].br) / 2);
      check("R2 bclk low run", lo, int'(VEC[k].br) / 2);
      check("R1 flag clear", bad, 0);
    end

    // R10 nominal bit clock
    bcode = 4'd5;
    measure(1, hi, lo);
    check("R10 bclk divide-by-8 period", hi + lo, 8);

    // R6 change during a high phase
    begin
      logic v;
      int g, rem_hi, old_lo, new_hi;
      g = 0;
      do begin tick(); v = bclk; g++; end while (v && g < 500);
      do begin tick(); v = bclk; g++; end while (!v && g < 1000);
      bcode = 4'd8;
      rem_hi = 0; old_lo = 0; new_hi = 0;
      tick(); v = bclk;
      while (v && g < 2000) begin rem_hi++; tick(); v = bclk; g++; end
      while (!v && g < 3000) begin old_lo++; tick(); v = bclk; g++; end
      while (v && g < 4000) begin new_hi++; tick(); v = bclk; g++; end
      check("R6 rest of old high phase", rem_hi, 3);
      check("R6 old low phase", old_lo, 4);
      check("R6 new high phase", new_hi, 12);
    end

    // R4 code 0 holds mclk low, flag high, bclk unaffected
    bcode = 4'd5; mcode = 4'd0;
    repeat (400) tick();
    errs = 0;
    for (int i = 0; i < 400; i++) begin
      tick();
      if (mclk !== 1'b0) errs++;
    end
    check("R4 mclk held low samples", errs, 0);
    check("R4 flag high for mclk code 0", bad, 1);
    measure(1, hi, lo);
    check("R4 bclk still divides", hi + lo, 8);

    // R7 pickup from held state: rises at next edge
    mcode = 4'd3;
    tick(); check("R7 mclk rises at first edge", mclk, 1);
    check("R7 flag clears same cycle", bad, 0);
    tick(); check("R7 second high sample", mclk, 1);
    tick(); check("R7 first low sample", mclk, 0);

    // R3 pass-through
    mcode = 4'd1;
    repeat (300) tick();
    errs = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5; if (mclk !== 1'b1) errs++;
      @(negedge clk); #5; if (mclk !== 1'b0) errs++;
    end
    check("R3 mclk follows module clock", errs, 0);

    // R4 flag from bclk channel
    bcode = 4'd0;
    repeat (300) tick();
    check("R4 flag high for bclk code 0", bad, 1);
    check("R4 bclk held low", bclk, 0);

    // R5 output enable
    bcode = 4'd5; mcode = 4'd5; oe = 1'b0;
    repeat (50) tick();
    errs = 0;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (mclk !== 1'b0) errs++;
    end
    check("R5 mclk gated low samples", errs, 0);
    measure(1, hi, lo);
    check("R5 bclk unaffected", hi + lo, 8);
    oe = 1'b1;
    measure(0, hi, lo);
    check("R5 mclk resumes", hi + lo, 8);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule